// File: doc/BRIEF.md
# Pin Test Vector Executor

This block runs one test vector against a socket of up to 24 device pins. The vector arrives as a stream of ASCII bytes, one code per pin in ascending pin order, over a ready/valid handshake whose final byte carries an end marker. Each code is decoded into a pin action. The block first issues every drive setting, then toggles the clock pins. Last, it probes the pins whose behaviour must be judged. It returns one ASCII result byte per pin.

The block does not touch the pins itself. For each pin it sends a command to an external per-pin classifier. The commands are: drive low, drive high, weak pull-down, full pull-up/pull-down classification, or a plain sample. For the two probing commands the block waits for a level response. Expectations have three values: high, low and high impedance. The block also supports an exploratory probe and a raw sample. Socket positions that the vector leaves empty are checked for high impedance.

Top module: `pin_vector_exec`

## Requirements
- R1: After reset, vec_ready is 1, res_valid and cmd_valid are 0, and err_flag is 0.
- R2: Drive commands use these cmd_op values: 0 = drive low, 1 = drive high, 2 = weak pull-down, 3 = classify, 4 = sample. Codes 'V' and '1' get one drive-high command. Codes 'G' and '0' get one drive-low command. Code 'X' gets one pull-down command and reports '.'. All five input codes (V, G, 1, 0, C) report '_'.
- R3: A '/' byte is discarded wherever it appears, including as the final byte. It takes no pin slot.
- R4: Codes 'L', 'H' and 'Z' issue a classify command. The response rsp_level uses 0 = low, 1 = high, 2 = high impedance. A match reports '.'. A mismatch reports the level seen, as 'L', 'H' or 'Z'.
- R5: Slots that are unfilled when the vector ends are classified and expected to be high impedance, in the same way as 'Z'.
- R6: Code '?' issues a classify command and reports '0', '1' or 'Z' for the level found.
- R7: Code 'S' issues a sample command and reports '1' for a high response and '0' otherwise.
- R8: All drive and pull commands come before any clock-high command. A pin coded 'C' gets exactly drive-low, drive-high, drive-low. Probe commands follow all drive commands, in strictly ascending pin order, with at most one outstanding. Results come in pin order, and res_last marks the last pin.
- R9: For a clock pin, the drive-low command comes NUM_PINS + max(phase_hold, 1) cycles after its drive-high command.
- R10: An unrecognised code reports '?' and sets err_flag. err_flag then stays set until reset.
- R11: Codes after the NUM_PINS-th are discarded and set err_flag.
- R12: vec_ready drops once the final byte is accepted and returns after the last result. Exactly NUM_PINS results are produced per vector. No command or result appears while vec_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | Vector byte valid |
| vec_ready | output | 1 | Block accepts vector bytes |
| vec_data | input | 8 | ASCII pin code |
| vec_last | input | 1 | Final byte of the vector |
| phase_hold | input | HOLD_W | Cycles each clock phase is held (0 acts as 1) |
| cmd_valid | output | 1 | Pin command valid |
| cmd_pin | output | PIN_W | Pin addressed by the command |
| cmd_op | output | 3 | Command opcode |
| rsp_valid | input | 1 | Classifier response valid |
| rsp_level | input | 2 | Level found by the classifier |
| res_valid | output | 1 | Result byte valid |
| res_data | output | 8 | ASCII result code |
| res_last | output | 1 | Result for the last pin |
| err_flag | output | 1 | Sticky malformed-vector flag |

## Verification
Several properties are checked by the assertions on every cycle: probes go out in strictly ascending pin order with no second command while one is pending, commands and results stay silent while the block is accepting input, the error flag never clears, and result bytes come only from the legal code set. The bench scenarios are needed for the rest. Only they can show the exact result character for each code and level pairing, and the low-high-low pattern on clock pins. They also cover the clock phase width for several hold settings, unused-slot filling, separator removal and overflow handling.

// File: rtl/pvx_pkg.sv
package pvx_pkg;

    typedef enum logic [3:0] {
        ACT_VCC,
        ACT_GND,
        ACT_HI,
        ACT_LO,
        ACT_CLK,
        ACT_EXP_L,
        ACT_EXP_H,
        ACT_EXP_Z,
        ACT_DONTCARE,
        ACT_PROBE,
        ACT_SAMPLE,
        ACT_UNUSED,
        ACT_BAD,
        ACT_SEP
    } pin_act_e;

    typedef enum logic [2:0] {
        OP_DRV_LO   = 3'd0,
        OP_DRV_HI   = 3'd1,
        OP_PULL_DN  = 3'd2,
        OP_CLASSIFY = 3'd3,
        OP_SAMPLE   = 3'd4
    } pin_op_e;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_HIZ  = 2'd2
    } pin_lvl_e;

    typedef enum logic [3:0] {
        ST_LOAD,
        ST_DRIVE,
        ST_SETTLE,
        ST_RISE,
        ST_HOLD_HI,
        ST_FALL,
        ST_HOLD_LO,
        ST_EVAL,
        ST_WAIT
    } exec_st_e;

endpackage

// File: rtl/pvx_code_decode.sv
module pvx_code_decode
    import pvx_pkg::*;
(
    input  logic [7:0] code,
    output pin_act_e   act
);
    always_comb begin
        case (code)
            "V":     act = ACT_VCC;
            "G":     act = ACT_GND;
            "1":     act = ACT_HI;
            "0":     act = ACT_LO;
            "C":     act = ACT_CLK;
            "L":     act = ACT_EXP_L;
            "H":     act = ACT_EXP_H;
            "Z":     act = ACT_EXP_Z;
            "X":     act = ACT_DONTCARE;
            "?":     act = ACT_PROBE;
            "S":     act = ACT_SAMPLE;
            "u":     act = ACT_UNUSED;
            "/":     act = ACT_SEP;
            default: act = ACT_BAD;
        endcase
    end
endmodule

// File: rtl/pvx_drive_map.sv
module pvx_drive_map
    import pvx_pkg::*;
(
    input  pin_act_e act,
    output logic     drv_en,
    output pin_op_e  drv_op,
    output logic     probe_en,
    output pin_op_e  probe_op
);
    always_comb begin
        drv_en   = 1'b0;
        drv_op   = OP_DRV_LO;
        probe_en = 1'b0;
        probe_op = OP_CLASSIFY;
        case (act)
            ACT_VCC, ACT_HI: begin
                drv_en = 1'b1;
                drv_op = OP_DRV_HI;
            end
            ACT_GND, ACT_LO, ACT_CLK: begin
                drv_en = 1'b1;
                drv_op = OP_DRV_LO;
            end
            ACT_DONTCARE: begin
                drv_en = 1'b1;
                drv_op = OP_PULL_DN;
            end
            ACT_EXP_L, ACT_EXP_H, ACT_EXP_Z, ACT_UNUSED, ACT_PROBE: begin
                probe_en = 1'b1;
                probe_op = OP_CLASSIFY;
            end
            ACT_SAMPLE: begin
                probe_en = 1'b1;
                probe_op = OP_SAMPLE;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pvx_result_encode.sv
module pvx_result_encode
    import pvx_pkg::*;
(
    input  pin_act_e   act,
    input  pin_lvl_e   lvl,
    output logic [7:0] ch
);
    logic [7:0] seen_ch;

    always_comb begin
        case (lvl)
            LVL_LOW:  seen_ch = "L";
            LVL_HIGH: seen_ch = "H";
            default:  seen_ch = "Z";
        endcase
    end

    always_comb begin
        case (act)
            ACT_VCC, ACT_GND, ACT_HI, ACT_LO, ACT_CLK: ch = "_";
            ACT_EXP_L:    ch = (lvl == LVL_LOW)  ? "." : seen_ch;
            ACT_EXP_H:    ch = (lvl == LVL_HIGH) ? "." : seen_ch;
            ACT_EXP_Z,
            ACT_UNUSED:   ch = (lvl == LVL_HIZ)  ? "." : seen_ch;
            ACT_DONTCARE: ch = ".";
            ACT_PROBE: begin
                case (lvl)
                    LVL_LOW:  ch = "0";
                    LVL_HIGH: ch = "1";
                    default:  ch = "Z";
                endcase
            end
            ACT_SAMPLE:   ch = (lvl == LVL_HIGH) ? "1" : "0";
            default:      ch = "?";
        endcase
    end
endmodule

// File: rtl/pin_vector_exec.sv
module pin_vector_exec
    import pvx_pkg::*;
#(
    parameter int  NUM_PINS = 24,
    parameter int  HOLD_W   = 16,
    localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vec_valid,
    output logic              vec_ready,
    input  logic [7:0]        vec_data,
    input  logic              vec_last,
    input  logic [HOLD_W-1:0] phase_hold,
    output logic              cmd_valid,
    output logic [PIN_W-1:0]  cmd_pin,
    output logic [2:0]        cmd_op,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_level,
    output logic              res_valid,
    output logic [7:0]        res_data,
    output logic              res_last,
    output logic              err_flag
);
    localparam int               CNT_W    = $clog2(NUM_PINS + 1);
    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_PINS);

    typedef struct packed {
        exec_st_e                    st;
        logic [PIN_W-1:0]            idx;
        logic [CNT_W-1:0]            fill;
        logic [HOLD_W-1:0]           cnt;
        logic                        err;
        pin_act_e [NUM_PINS-1:0]     slots;
    } ctl_t;

    ctl_t q, d;

    pin_act_e          in_act;
    pin_act_e          cur_act;
    pin_lvl_e          rsp_lvl;
    logic              drv_en;
    pin_op_e           drv_op;
    logic              probe_en;
    pin_op_e           probe_op;
    logic [7:0]        enc_ch;
    logic [HOLD_W-1:0] hold_init;
    logic              last_pin;

    assign cur_act   = q.slots[q.idx];
    assign rsp_lvl   = pin_lvl_e'(rsp_level);
    assign hold_init = (phase_hold == '0) ? HOLD_W'(1) : phase_hold;
    assign last_pin  = (q.idx == LAST_PIN);

    pvx_code_decode u_dec (
        .code (vec_data),
        .act  (in_act)
    );

    pvx_drive_map u_map (
        .act      (cur_act),
        .drv_en   (drv_en),
        .drv_op   (drv_op),
        .probe_en (probe_en),
        .probe_op (probe_op)
    );

    pvx_result_encode u_enc (
        .act (cur_act),
        .lvl (rsp_lvl),
        .ch  (enc_ch)
    );

    always_comb begin
        d         = q;
        vec_ready = (q.st == ST_LOAD);
        cmd_valid = 1'b0;
        cmd_pin   = q.idx;
        cmd_op    = OP_DRV_LO;
        res_valid = 1'b0;
        res_data  = enc_ch;
        res_last  = 1'b0;

        case (q.st)
            ST_LOAD: begin
                if (vec_valid) begin
                    if (in_act != ACT_SEP) begin
                        if (q.fill < FULL_CNT) begin
                            d.slots[q.fill[PIN_W-1:0]] = in_act;
                            d.fill = q.fill + 1'b1;
                        end else begin
                            d.err = 1'b1;
                        end
                        if (in_act == ACT_BAD) begin
                            d.err = 1'b1;
                        end
                    end
                    if (vec_last) begin
                        d.st  = ST_DRIVE;
                        d.idx = '0;
                    end
                end
            end

            ST_DRIVE: begin
                cmd_valid = drv_en;
                cmd_op    = drv_op;
                if (last_pin) begin
                    d.st  = ST_SETTLE;
                    d.cnt = hold_init;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end

            ST_SETTLE, ST_HOLD_HI, ST_HOLD_LO: begin
                if (q.cnt <= HOLD_W'(1)) begin
                    d.idx = '0;
                    case (q.st)
                        ST_SETTLE:  d.st = ST_RISE;
                        ST_HOLD_HI: d.st = ST_FALL;
                        default:    d.st = ST_EVAL;
                    endcase
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end

            ST_RISE, ST_FALL: begin
                if (cur_act == ACT_CLK) begin
                    cmd_valid = 1'b1;
                    cmd_op    = (q.st == ST_RISE) ? OP_DRV_HI : OP_DRV_LO;
                end
                if (last_pin) begin
                    d.st  = (q.st == ST_RISE) ? ST_HOLD_HI : ST_HOLD_LO;
                    d.cnt = hold_init;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end

            ST_EVAL, ST_WAIT: begin
                if (q.st == ST_EVAL && probe_en) begin
                    cmd_valid = 1'b1;
                    cmd_op    = probe_op;
                    d.st      = ST_WAIT;
                end else if (q.st == ST_EVAL || rsp_valid) begin
                    res_valid = 1'b1;
                    res_last  = last_pin;
                    if (last_pin) begin
                        d.st   = ST_LOAD;
                        d.idx  = '0;
                        d.fill = '0;
                        for (int i = 0; i < NUM_PINS; i++) begin
                            d.slots[i] = ACT_UNUSED;
                        end
                    end else begin
                        d.st  = ST_EVAL;
                        d.idx = q.idx + 1'b1;
                    end
                end
            end

            default: d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_LOAD;
            q.idx  <= '0;
            q.fill <= '0;
            q.cnt  <= '0;
            q.err  <= 1'b0;
            for (int i = 0; i < NUM_PINS; i++) begin
                q.slots[i] <= ACT_UNUSED;
            end
        end else begin
            q <= d;
        end
    end

    assign err_flag = q.err;

endmodule

// File: rtl/pvx_checker.sv
module pvx_checker #(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_ready,
    input logic             cmd_valid,
    input logic [PIN_W-1:0] cmd_pin,
    input logic [2:0]       cmd_op,
    input logic             res_valid,
    input logic [7:0]       res_data,
    input logic             res_last,
    input logic             err_flag
);
    logic             probe;
    logic             seen_q;
    logic [PIN_W-1:0] prev_q;

    assign probe = cmd_valid && (cmd_op == 3'd3 || cmd_op == 3'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            prev_q <= '0;
        end else if (res_valid && res_last) begin
            seen_q <= 1'b0;
        end else if (probe) begin
            seen_q <= 1'b1;
            prev_q <= cmd_pin;
        end
    end

    AST_PROBE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (probe && seen_q) |-> (cmd_pin > prev_q)); // R8

    AST_SINGLE_PROBE: assert property (@(posedge clk) disable iff (!rst_n)
        probe |=> !cmd_valid); // R8

    AST_NO_CMD_WITH_RES: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && res_valid)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ready |-> (!cmd_valid && !res_valid)); // R12

    AST_LAST_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_last) |=> vec_ready); // R12

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag); // R10

    AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (int'(cmd_pin) < NUM_PINS && cmd_op <= 3'd4)); // R2

    AST_RES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_data inside {".", "_", "H", "L", "Z", "0", "1", "?"})); // R4

endmodule

bind pin_vector_exec pvx_checker #(
    .NUM_PINS (NUM_PINS),
    .PIN_W    (PIN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_ready (vec_ready),
    .cmd_valid (cmd_valid),
    .cmd_pin   (cmd_pin),
    .cmd_op    (cmd_op),
    .res_valid (res_valid),
    .res_data  (res_data),
    .res_last  (res_last),
    .err_flag  (err_flag)
);

// File: tb/pin_vector_exec_tb.sv
module pin_vector_exec_tb;
    localparam int N  = 24;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vec_valid = 1'b0;
    logic          vec_ready;
    logic [7:0]    vec_data = 8'h00;
    logic          vec_last = 1'b0;
    logic [15:0]   phase_hold = 16'd3;
    logic          cmd_valid;
    logic [PW-1:0] cmd_pin;
    logic [2:0]    cmd_op;
    logic          rsp_valid = 1'b0;
    logic [1:0]    rsp_level = 2'd0;
    logic          res_valid;
    logic [7:0]    res_data;
    logic          res_last;
    logic          err_flag;

    always #5 clk = ~clk;

    pin_vector_exec #(.NUM_PINS(N), .HOLD_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data), .vec_last(vec_last),
        .phase_hold(phase_hold),
        .cmd_valid(cmd_valid), .cmd_pin(cmd_pin), .cmd_op(cmd_op),
        .rsp_valid(rsp_valid), .rsp_level(rsp_level),
        .res_valid(res_valid), .res_data(res_data), .res_last(res_last),
        .err_flag(err_flag)
    );

    int  n_chk = 0;
    int  n_fail = 0;
    int  lvl_m [N];
    int  smp_m [N];
    byte codes_m [N];
    int  seq_cnt [N];
    int  seq [N][3];
    int  first_t [N];
    int  hi_t [N];
    int  lo_t [N];
    int  order_err = 0;
    int  last_probe = -1;
    int  tcyc = 0;
    bit  pend = 0;
    int  pend_pin = 0;
    int  pend_op = 0;
    int  dly = 0;
    int  res_cnt = 0;
    byte   exp_q [$];
    string tag_q [$];

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    function automatic byte seen_of(input int l);
        return (l == 0) ? "L" : (l == 1) ? "H" : "Z";
    endfunction

    function automatic byte exp_ch(input byte c, input int l, input int s);
        case (c)
            "V", "G", "1", "0", "C": return "_";
            "L":      return (l == 0) ? "." : seen_of(l);
            "H":      return (l == 1) ? "." : seen_of(l);
            "Z", "u": return (l == 2) ? "." : seen_of(l);
            "X":      return ".";
            "?":      return (l == 0) ? "0" : (l == 1) ? "1" : "Z";
            "S":      return (s == 1) ? "1" : "0";
            default:  return "?";
        endcase
    endfunction

    function automatic string tag_of(input byte c);
        case (c)
            "V", "G", "1", "0", "C", "X": return "R2";
            "L", "H", "Z": return "R4";
            "u":           return "R5";
            "?":           return "R6";
            "S":           return "R7";
            default:       return "R10";
        endcase
    endfunction

    always @(posedge clk) tcyc = tcyc + 1;

    // classifier model: observe commands
    always @(negedge clk) begin : obs
        int p;
        if (rst_n && cmd_valid) begin
            p = int'(cmd_pin);
            if (p < N) begin
                if (cmd_op <= 3'd2) begin
                    if (last_probe >= 0) order_err++;
                    if (seq_cnt[p] == 0) first_t[p] = tcyc;
                    if (seq_cnt[p] < 3) seq[p][seq_cnt[p]] = int'(cmd_op);
                    seq_cnt[p]++;
                    if (cmd_op == 3'd1) hi_t[p] = tcyc;
                    if (cmd_op == 3'd0) lo_t[p] = tcyc;
                end else begin
                    if (p <= last_probe) order_err++;
                    last_probe = p;
                    pend     = 1'b1;
                    pend_pin = p;
                    pend_op  = int'(cmd_op);
                    dly      = 2;
                end
            end
        end
    end

    // classifier model: respond
    always @(posedge clk) begin
        #1;
        rsp_valid = 1'b0;
        if (pend) begin
            if (dly == 0) begin
                rsp_valid = 1'b1;
                rsp_level = (pend_op == 4) ? 2'(smp_m[pend_pin]) : 2'(lvl_m[pend_pin]);
                pend = 1'b0;
            end else begin
                dly--;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin : mon
        byte   e;
        string t;
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R12", "unexpected result byte", int'(res_data), 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(res_data == e, t, $sformatf("pin %0d result", res_cnt), int'(res_data), int'(e));
                chk(res_last == (res_cnt == N - 1), "R8", $sformatf("pin %0d last flag", res_cnt),
                    int'(res_last), int'(res_cnt == N - 1));
            end
            res_cnt++;
        end
    end

    task automatic check_drive(input int hold);
        int bad = 0;
        int gap_bad = 0;
        int has_clk = 0;
        int max_drv = -1;
        int min_hi = 1 << 30;
        int want_gap;
        bit ok;
        want_gap = N + ((hold == 0) ? 1 : hold);
        for (int p = 0; p < N; p++) begin
            case (codes_m[p])
                "V", "1": ok = (seq_cnt[p] == 1) && (seq[p][0] == 1);
                "G", "0": ok = (seq_cnt[p] == 1) && (seq[p][0] == 0);
                "X":      ok = (seq_cnt[p] == 1) && (seq[p][0] == 2);
                "C": begin
                    ok = (seq_cnt[p] == 3) && (seq[p][0] == 0) && (seq[p][1] == 1) && (seq[p][2] == 0);
                    has_clk = 1;
                    if (lo_t[p] - hi_t[p] != want_gap) gap_bad++;
                    if (hi_t[p] < min_hi) min_hi = hi_t[p];
                end
                default:  ok = (seq_cnt[p] == 0);
            endcase
            if (!ok) bad++;
            if (seq_cnt[p] > 0 && first_t[p] > max_drv) max_drv = first_t[p];
        end
        chk(bad == 0, "R2 R8", "pins with wrong drive command sequence", bad, 0);
        chk(order_err == 0, "R8", "probe ordering violations", order_err, 0);
        if (has_clk != 0) begin
            chk(min_hi > max_drv, "R8", "first clock high after drive phase", min_hi, max_drv + 1);
            chk(gap_bad == 0, "R9", "clock pins with wrong phase width", gap_bad, 0);
        end
    endtask

    task automatic run_vec(input string v, input int hold, input string extra);
        int  pin = 0;
        byte c;
        phase_hold = 16'(hold);
        for (int p = 0; p < N; p++) begin
            codes_m[p] = "u";
            seq_cnt[p] = 0;
            first_t[p] = -1;
            hi_t[p]    = -1;
            lo_t[p]    = -1;
        end
        order_err  = 0;
        last_probe = -1;
        res_cnt    = 0;
        for (int i = 0; i < v.len(); i++) begin
            c = v[i];
            if (c != "/") begin
                if (pin < N) codes_m[pin] = c;
                pin++;
            end
        end
        for (int p = 0; p < N; p++) begin
            exp_q.push_back(exp_ch(codes_m[p], lvl_m[p], smp_m[p]));
            tag_q.push_back({tag_of(codes_m[p]), extra});
        end
        while (!vec_ready) begin
            @(posedge clk);
            #1;
        end
        for (int i = 0; i < v.len(); i++) begin
            vec_valid = 1'b1;
            vec_data  = v[i];
            vec_last  = (i == v.len() - 1);
            @(posedge clk);
            #1;
        end
        vec_valid = 1'b0;
        vec_last  = 1'b0;
        chk(vec_ready == 1'b0, "R12", "ready after final byte", int'(vec_ready), 0);
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk);
        #1;
        chk(res_cnt == N, "R12", "results per vector", res_cnt, N);
        chk(vec_ready == 1'b1, "R12", "ready after last result", int'(vec_ready), 1);
        check_drive(hold);
    endtask

    task automatic models_default();
        for (int p = 0; p < N; p++) begin
            lvl_m[p] = 2;
            smp_m[p] = 0;
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        report();
    end

    initial begin : main
        models_default();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(vec_ready == 1'b1, "R1", "ready after reset", int'(vec_ready), 1);
        chk(res_valid == 1'b0, "R1", "result valid after reset", int'(res_valid), 0);
        chk(cmd_valid == 1'b0, "R1", "command valid after reset", int'(cmd_valid), 0);
        chk(err_flag == 1'b0, "R1", "error flag after reset", int'(err_flag), 0);

        // inputs, clock, don't care, matching expectations
        models_default();
        lvl_m[6] = 0;
        lvl_m[7] = 1;
        lvl_m[8] = 2;
        run_vec("10VG/CXLH/Z", 3, "");
        chk(err_flag == 1'b0, "R10", "error flag on clean vector", int'(err_flag), 0);

        // mismatches and unused-slot mismatch (R4, R5)
        models_default();
        lvl_m[0] = 1; lvl_m[1] = 2; lvl_m[2] = 0;
        lvl_m[3] = 2; lvl_m[4] = 0; lvl_m[5] = 1;
        lvl_m[20] = 1;
        run_vec("LHZ/LHZ", 1, "");

        // exploratory and sample codes (R6, R7)
        models_default();
        lvl_m[0] = 0; lvl_m[1] = 1; lvl_m[2] = 2;
        smp_m[3] = 1; lvl_m[3] = 0;
        smp_m[4] = 0; lvl_m[4] = 1;
        run_vec("???SS", 2, "");

        // full vector, separators everywhere incl. final byte, hold 0 (R3, R9)
        models_default();
        run_vec("////C1C0/CCCC/1111/0000/VVGG/XXXX/", 0, " R3");

        // unrecognised code (R10)
        models_default();
        lvl_m[3] = 0;
        run_vec("1Q0L", 7, "");
        chk(err_flag == 1'b1, "R10", "error flag after bad code", int'(err_flag), 1);

        models_default();
        lvl_m[0] = 1;
        lvl_m[1] = 0;
        run_vec("HL", 2, "");
        chk(err_flag == 1'b1, "R10", "error flag stays set", int'(err_flag), 1);

        // reset clears, then overflow (R11)
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(err_flag == 1'b0, "R1", "error flag cleared by reset", int'(err_flag), 0);
        models_default();
        run_vec("00000000000000000000000011", 1, " R11");
        chk(err_flag == 1'b1, "R11", "error flag after overflow", int'(err_flag), 1);

        repeat (5) @(posedge clk);
        report();
    end

endmodule